// File: doc/BRIEF.md
# Register-Commanded MDIO Management Master

This block drives a clause-22 management bus (MDC clock and bidirectional MDIO data) toward a set of internal PHYs. Software controls it through one 32-bit command/status word on a simple synchronous register bus. A single write holds all the fields of one access: direction, PHY and register address, and write data. Setting the start flag in that write launches one complete read or write frame on the wire. The start flag reads back as a busy indication until the last bit has been clocked out. When a read finishes, the 16 bits returned by the PHY are found in the data field of the same word.

A separate enable flag decides who owns the PHY management lines. While it is set, the internal master drives MDC and MDIO and the external pass-through is cut off. While it is clear, an external MDC/MDIO pair is routed straight to the PHYs and the internal master cannot start. A typical use maps switch ports 1 to 5 onto PHY addresses 0 to 4. Software then polls the busy flag after each command.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 32'h0000_0000, the enable flag is clear, and the PHY lines follow the external pass-through.
- R2: A register write with bit 31 (start/busy) and bit 30 (enable) both set starts one frame. Bit 31 then reads 1 for exactly 2*DIV_HALF*N clock cycles after the accepting edge, where N is 64 with preamble and 32 without, and then reads 0.
- R3: A register write with bit 31 set but bit 30 clear stores the other fields, leaves bit 31 at 0, and starts no frame.
- R4: A frame starts with 32 one-bits of preamble unless bit 26 is set, in which case there is no preamble. It continues, MSB first, with start bits 01, opcode 10 for a read (bit 27 = 1) or 01 for a write (bit 27 = 0), the PHY address from bits 25:21, and the register address from bits 20:16.
- R5: A write frame follows the register address with turnaround bits 10 and then data bits 15:0, MSB first.
- R6: A read frame releases MDIO (output enable low) from the first turnaround bit to the end of the frame. The PHY drives 0 on the second turnaround bit. The 16 bits sampled afterwards replace bits 15:0 of the command word when busy clears.
- R7: MDC idles low, and within a frame it has a period of exactly 2*DIV_HALF clock cycles. There is one MDC rising edge per frame bit. The master changes a driven MDIO value only on a falling MDC edge, and it samples read data on rising edges.
- R8: While busy, a register write changes only bit 30. The direction, preamble, address and data fields keep their values, and the running frame carries the original fields.
- R9: With the enable flag set, the PHY lines carry the internal master's MDC/MDIO, the external MDC and MDIO inputs are ignored, and the external read-back input is held at 1. With the enable flag clear, the PHY MDC, MDIO and output-enable follow the external inputs, and the PHY MDIO is returned to the external side.
- R10: Read-back bits 29 and 28 are always 0. Every other bit returns the stored field, with bit 31 showing the live busy state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe for the command word |
| reg_wdata | input | 32 | Command word to be written |
| reg_rdata | output | 32 | Live command/status word |
| ext_mdc | input | 1 | MDC from the external pass-through master |
| ext_mdio_out | input | 1 | MDIO value driven by the external master |
| ext_mdio_oe | input | 1 | Output enable of the external master |
| ext_mdio_in | output | 1 | MDIO value returned to the external master |
| phy_mdc | output | 1 | MDC toward the internal PHYs |
| phy_mdio_out | output | 1 | MDIO value driven toward the PHYs |
| phy_mdio_oe | output | 1 | Output enable for phy_mdio_out |
| phy_mdio_in | input | 1 | Resolved MDIO line value seen at the PHYs |

## Verification
The assertions assume three things about the inputs. Register writes are single-cycle strobes. The PHY drives MDIO only while the master has released it. The enable flag is toggled mid-frame only inside the preamble, where the frame bits cannot be disturbed. The stimulus keeps to these assumptions. A bench PHY model drives the line only during the read turnaround and data phases. Random commands are always issued with the enable flag set and only after busy has cleared. The single directed enable toggle during a frame lands within its first few cycles, long before the preamble ends.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    localparam int CMD_W      = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int TA_POS     = 14;
    localparam int DATA_POS   = 16;
    localparam int BIT_CNT_W  = $clog2(PRE_BITS > FRAME_BITS ? PRE_BITS : FRAME_BITS);

    localparam int BUSY_BIT  = 31;
    localparam int EN_BIT    = 30;
    localparam int RD_BIT    = 27;
    localparam int NOPRE_BIT = 26;
    localparam int PHY_LSB   = 21;
    localparam int REG_LSB   = 16;

    typedef struct packed {
        logic              busy;
        logic              en;
        logic              rd;
        logic              nopre;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_FRAME = 2'd2
    } phase_e;

    function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.busy  = w[BUSY_BIT];
        c.en    = w[EN_BIT];
        c.rd    = w[RD_BIT];
        c.nopre = w[NOPRE_BIT];
        c.phy   = w[PHY_LSB +: ADDR_W];
        c.regad = w[REG_LSB +: ADDR_W];
        c.data  = w[DATA_W-1:0];
        return c;
    endfunction

    function automatic logic [CMD_W-1:0] pack_cmd(input cmd_t c);
        logic [CMD_W-1:0] w;
        w                      = '0;
        w[BUSY_BIT]            = c.busy;
        w[EN_BIT]              = c.en;
        w[RD_BIT]              = c.rd;
        w[NOPRE_BIT]           = c.nopre;
        w[PHY_LSB +: ADDR_W]   = c.phy;
        w[REG_LSB +: ADDR_W]   = c.regad;
        w[DATA_W-1:0]          = c.data;
        return w;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_ev,
    output logic fall_ev
);

    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t div_d, div_q;
    logic tick;

    always_comb begin
        div_d = div_q;
        tick  = run && (div_q.cnt == LAST);
        if (!run) begin
            div_d = '0;
        end else if (tick) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc     = div_q.mdc;
    assign rise_ev = tick & ~div_q.mdc;
    assign fall_ev = tick &  div_q.mdc;

    // R7: the clock is parked low once the engine stops requesting it
    a_r7_mdc_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc)
        else $error("R7 MDC not low while idle");

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_rd,
    input  logic              cmd_nopre,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              mdio_in,
    output logic              active,
    output logic              done,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [BIT_CNT_W-1:0] PRE_LAST   = BIT_CNT_W'(PRE_BITS - 1);
    localparam logic [BIT_CNT_W-1:0] FRAME_LAST = BIT_CNT_W'(FRAME_BITS - 1);
    localparam logic [BIT_CNT_W-1:0] TA_FIRST   = BIT_CNT_W'(TA_POS);
    localparam logic [BIT_CNT_W-1:0] DATA_FIRST = BIT_CNT_W'(DATA_POS);

    typedef struct packed {
        phase_e                phase;
        logic [BIT_CNT_W-1:0]  cnt;
        logic [FRAME_BITS-1:0] sr;
        logic                  rd;
        logic [DATA_W-1:0]     cap;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        done  = 1'b0;
        unique case (eng_q.phase)
            PH_IDLE: begin
                if (start) begin
                    eng_d.phase = cmd_nopre ? PH_FRAME : PH_PRE;
                    eng_d.cnt   = '0;
                    eng_d.rd    = cmd_rd;
                    eng_d.sr    = {2'b01,
                                   cmd_rd ? 2'b10 : 2'b01,
                                   cmd_phy, cmd_reg,
                                   cmd_rd ? 2'b11 : 2'b10,
                                   cmd_rd ? {DATA_W{1'b1}} : cmd_data};
                end
            end
            PH_PRE: begin
                if (fall_ev) begin
                    if (eng_q.cnt == PRE_LAST) begin
                        eng_d.phase = PH_FRAME;
                        eng_d.cnt   = '0;
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
            end
            PH_FRAME: begin
                if (rise_ev && eng_q.rd && (eng_q.cnt >= DATA_FIRST)) begin
                    eng_d.cap = {eng_q.cap[DATA_W-2:0], mdio_in};
                end
                if (fall_ev) begin
                    if (eng_q.cnt == FRAME_LAST) begin
                        eng_d.phase = PH_IDLE;
                        eng_d.cnt   = '0;
                        done        = 1'b1;
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                        eng_d.sr  = {eng_q.sr[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end
            default: eng_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign active   = (eng_q.phase != PH_IDLE);
    assign mdio_out = (eng_q.phase == PH_FRAME) ? eng_q.sr[FRAME_BITS-1] : 1'b1;
    assign mdio_oe  = (eng_q.phase == PH_PRE) ||
                      ((eng_q.phase == PH_FRAME) && !(eng_q.rd && (eng_q.cnt >= TA_FIRST)));
    assign rd_data  = eng_q.cap;

    // R2: a new frame is only launched from the idle phase
    a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active)
        else $error("R2 start while a frame is running");

    // R7: driven data moves only together with a falling MDC edge
    a_r7_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fall_ev) |=> $stable(mdio_out))
        else $error("R7 MDIO changed without falling MDC");

    // R6: the capture register never moves outside a read frame
    a_r6_capture_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!active || !eng_q.rd) |=> $stable(rd_data))
        else $error("R6 capture changed outside a read");

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ext_mdc,
    input  logic        ext_mdio_out,
    input  logic        ext_mdio_oe,
    output logic        ext_mdio_in,
    output logic        phy_mdc,
    output logic        phy_mdio_out,
    output logic        phy_mdio_oe,
    input  logic        phy_mdio_in
);

    cmd_t              cmd_d, cmd_q, wr_cmd;
    logic              start;
    logic              eng_active, eng_done, eng_mdio_out, eng_mdio_oe;
    logic [DATA_W-1:0] eng_cap;
    logic              int_mdc, rise_ev, fall_ev;
    logic              unused_rsvd;

    assign wr_cmd      = unpack_cmd(reg_wdata);
    assign unused_rsvd = ^reg_wdata[29:28];

    always_comb begin
        cmd_d = cmd_q;
        start = 1'b0;
        if (reg_wr && !cmd_q.busy) begin
            cmd_d      = wr_cmd;
            start      = wr_cmd.busy && wr_cmd.en;
            cmd_d.busy = start;
        end else if (reg_wr) begin
            cmd_d.en = wr_cmd.en;
        end
        if (eng_done) begin
            cmd_d.busy = 1'b0;
            if (cmd_q.rd) cmd_d.data = eng_cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign reg_rdata = pack_cmd(cmd_q);

    mdio_mdc_gen #(
        .DIV_HALF (DIV_HALF)
    ) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (eng_active),
        .mdc     (int_mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_rd    (wr_cmd.rd),
        .cmd_nopre (wr_cmd.nopre),
        .cmd_phy   (wr_cmd.phy),
        .cmd_reg   (wr_cmd.regad),
        .cmd_data  (wr_cmd.data),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .mdio_in   (phy_mdio_in),
        .active    (eng_active),
        .done      (eng_done),
        .mdio_out  (eng_mdio_out),
        .mdio_oe   (eng_mdio_oe),
        .rd_data   (eng_cap)
    );

    always_comb begin
        if (cmd_q.en) begin
            phy_mdc      = int_mdc;
            phy_mdio_out = eng_mdio_out;
            phy_mdio_oe  = eng_mdio_oe;
            ext_mdio_in  = 1'b1;
        end else begin
            phy_mdc      = ext_mdc;
            phy_mdio_out = ext_mdio_out;
            phy_mdio_oe  = ext_mdio_oe;
            ext_mdio_in  = phy_mdio_in;
        end
    end

    // R2: the visible busy flag and the running engine agree every cycle
    a_r2_busy_tracks_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q.busy == eng_active)
        else $error("R2 busy flag and engine disagree");

    // R3: no frame is launched while the enable flag is clear in the write
    a_r3_no_start_without_en: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !cmd_q.busy && !reg_wdata[EN_BIT]) |=> !eng_active)
        else $error("R3 frame started without enable");

    // R8: addressing and direction fields hold while a frame is pending
    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q.busy |=> $stable({cmd_q.rd, cmd_q.nopre, cmd_q.phy, cmd_q.regad}))
        else $error("R8 fields changed while busy");

    // R8: data field is frozen until the completing cycle
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.busy && !eng_done) |=> $stable(cmd_q.data))
        else $error("R8 data changed while busy");

    // R1: reset leaves the master disabled and idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!cmd_q.en && !cmd_q.busy))
        else $error("R1 reset state wrong");

endmodule

// File: tb/tb_mdio_cmd_master.sv
module tb_mdio_cmd_master;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 2;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_mdc = 1'b0;
    logic        ext_mdio_out = 1'b1;
    logic        ext_mdio_oe = 1'b0;
    logic        ext_mdio_in;
    logic        phy_mdc;
    logic        phy_mdio_out;
    logic        phy_mdio_oe;
    logic        phy_mdio_in;

    logic drv_en  = 1'b0;
    logic drv_val = 1'b1;
    logic tb_pull = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [15:0] model [32];

    assign phy_mdio_in = phy_mdio_oe ? phy_mdio_out : (drv_en ? drv_val : tb_pull);

    mdio_cmd_master #(.DIV_HALF(DIV_HALF)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ext_mdc      (ext_mdc),
        .ext_mdio_out (ext_mdio_out),
        .ext_mdio_oe  (ext_mdio_oe),
        .ext_mdio_in  (ext_mdio_in),
        .phy_mdc      (phy_mdc),
        .phy_mdio_out (phy_mdio_out),
        .phy_mdio_oe  (phy_mdio_oe),
        .phy_mdio_in  (phy_mdio_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] init_val(input int r);
        return 16'((r * 16'h0401) ^ 16'hC35A);
    endfunction

    function automatic logic [31:0] cmd_word(input bit rd, input bit nopre,
                                             input logic [4:0] phy, input logic [4:0] rg,
                                             input logic [15:0] data);
        return {1'b1, 1'b1, 2'b00, rd, nopre, phy, rg, data};
    endfunction

    // ---------------- PHY responder model ----------------
    int          rsp_pos = 0;
    bit          rsp_hunt = 1'b1;
    logic        rsp_prev = 1'b1;
    int          rsp_ones = 0;
    int          rsp_frames = 0;
    logic [31:0] rsp_fb = '0;
    logic [1:0]  rsp_op = '0;
    logic [4:0]  rsp_phy = '0;
    logic [4:0]  rsp_reg = '0;
    logic [1:0]  rsp_ta = '0;
    logic [15:0] rsp_wd = '0;
    logic        rsp_ta_oe = 1'b0;
    logic        rsp_data_oe = 1'b0;
    logic [15:0] rsp_mem [32];
    logic        rsp_b;

    always @(posedge phy_mdc) begin
        rsp_b = phy_mdio_in;
        if (rsp_hunt) begin
            if (rsp_prev && !rsp_b) begin
                rsp_hunt = 1'b0;
                rsp_pos  = 1;
                rsp_fb   = '0;
                rsp_op   = '0;
            end else if (rsp_b) begin
                rsp_ones++;
            end
            rsp_prev = rsp_b;
        end else begin
            rsp_fb = {rsp_fb[30:0], rsp_b};
            if (rsp_pos == 3)  rsp_op  = rsp_fb[1:0];
            if (rsp_pos == 8)  rsp_phy = rsp_fb[4:0];
            if (rsp_pos == 13) rsp_reg = rsp_fb[4:0];
            if (rsp_pos == 14) rsp_ta_oe = phy_mdio_oe;
            if (rsp_pos == 15) rsp_ta = rsp_fb[1:0];
            if (rsp_pos >= 16 && rsp_op == 2'b10 && phy_mdio_oe) rsp_data_oe = 1'b1;
            if (rsp_pos == 31) begin
                rsp_wd = rsp_fb[15:0];
                if (rsp_op == 2'b01) rsp_mem[rsp_reg] = rsp_fb[15:0];
                rsp_frames++;
                rsp_hunt = 1'b1;
                rsp_prev = 1'b1;
            end
            rsp_pos++;
        end
    end

    always @(negedge phy_mdc) begin
        if (!rsp_hunt && rsp_op == 2'b10 && rsp_pos >= 15) begin
            drv_en  = 1'b1;
            drv_val = (rsp_pos == 15) ? 1'b0 : rsp_mem[rsp_reg][31 - rsp_pos];
        end else begin
            drv_en = 1'b0;
        end
    end

    // ---------------- line monitor (sampled away from the clock edge) ----------------
    int   busy_cnt = 0, rise_cnt = 0, gap = 0, gmin = 0, gmax = 0, mdio_bad = 0;
    bit   gap_ok = 1'b0;
    logic mdc_p = 1'b0, mdio_p = 1'b1, oe_p = 1'b0;

    always @(negedge clk) begin
        if (reg_rdata[31]) busy_cnt++;
        if (phy_mdc && !mdc_p) begin
            rise_cnt++;
            if (gap_ok) begin
                if (gap < gmin) gmin = gap;
                if (gap > gmax) gmax = gap;
            end
            gap    = 0;
            gap_ok = 1'b1;
        end
        gap++;
        if (oe_p && phy_mdio_oe && (phy_mdio_out != mdio_p) && !(mdc_p && !phy_mdc)) mdio_bad++;
        mdc_p  = phy_mdc;
        mdio_p = phy_mdio_out;
        oe_p   = phy_mdio_oe;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] w);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic mon_reset();
        busy_cnt = 0; rise_cnt = 0; gap = 0; gap_ok = 1'b0;
        gmin = 1 << 20; gmax = 0; mdio_bad = 0;
    endtask

    task automatic rsp_clear();
        rsp_hunt = 1'b1; rsp_prev = 1'b1; rsp_ones = 0; rsp_frames = 0;
        rsp_ta_oe = 1'b0; rsp_data_oe = 1'b0; drv_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 4000 && reg_rdata[31]; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_txn(input bit rd, input bit nopre, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] data, input bit timed);
        int nb;
        nb = nopre ? 32 : 64;
        if (timed) begin
            chk(busy_cnt == 2*DIV_HALF*nb, "R2 busy duration", busy_cnt, 2*DIV_HALF*nb);
            chk(rise_cnt == nb, "R7 MDC rising edges", rise_cnt, nb);
            chk(gmin == 2*DIV_HALF && gmax == 2*DIV_HALF, "R7 MDC period", {gmin[15:0], gmax[15:0]}, 2*DIV_HALF);
            chk(mdio_bad == 0, "R7 MDIO moved off falling edge", mdio_bad, 0);
            chk(rsp_ones == (nopre ? 0 : 32), "R4 preamble length", rsp_ones, nopre ? 0 : 32);
        end
        chk(rsp_frames == 1, "R4 frame decoded", rsp_frames, 1);
        chk(rsp_op == (rd ? 2'b10 : 2'b01), "R4 opcode", rsp_op, rd ? 2'b10 : 2'b01);
        chk(rsp_phy == phy, "R4 PHY address", rsp_phy, phy);
        chk(rsp_reg == rg, "R4 register address", rsp_reg, rg);
        chk(reg_rdata[31] == 1'b0 && reg_rdata[25:16] == {phy, rg}, "R10 readback fields",
            reg_rdata, {1'b0, 5'b0, phy, rg, 16'h0});
        if (rd) begin
            chk(reg_rdata[15:0] == model[rg], "R6 read data", reg_rdata[15:0], model[rg]);
            chk(rsp_ta_oe == 1'b0, "R6 turnaround released", rsp_ta_oe, 0);
            chk(rsp_data_oe == 1'b0, "R6 data phase released", rsp_data_oe, 0);
        end else begin
            chk(rsp_ta == 2'b10, "R5 write turnaround", rsp_ta, 2'b10);
            chk(rsp_wd == data, "R5 write data", rsp_wd, data);
            model[rg] = data;
        end
    endtask

    task automatic txn(input bit rd, input bit nopre, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] data);
        mon_reset();
        rsp_clear();
        reg_write(cmd_word(rd, nopre, phy, rg, data));
        wait_idle();
        check_txn(rd, nopre, phy, rg, data, 1'b1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1789);
        for (int i = 0; i < 32; i++) begin
            model[i]   = init_val(i);
            rsp_mem[i] = init_val(i);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and pass-through
        chk(reg_rdata == 32'h0, "R1 reset word", reg_rdata, 32'h0);
        ext_mdc = 1'b1;
        @(negedge clk);
        chk(phy_mdc == 1'b1, "R1 reset pass-through MDC", phy_mdc, 1);
        ext_mdc = 1'b0;

        // R9: pass-through while disabled
        ext_mdio_out = 1'b0; ext_mdio_oe = 1'b1;
        @(negedge clk);
        chk(phy_mdio_out == 1'b0 && phy_mdio_oe == 1'b1, "R9 pass-through drive",
            {phy_mdio_oe, phy_mdio_out}, 2'b10);
        ext_mdio_oe = 1'b0; ext_mdio_out = 1'b1; tb_pull = 1'b0;
        @(negedge clk);
        chk(ext_mdio_in == 1'b0, "R9 pass-through return", ext_mdio_in, 0);
        tb_pull = 1'b1;

        // R3: start without enable
        mon_reset();
        reg_write(32'hBFFF_FFFF);
        repeat (12) @(negedge clk);
        chk(reg_rdata == 32'h0FFF_FFFF, "R3 start ignored without enable", reg_rdata, 32'h0FFF_FFFF);

        // R10: reserved bits read zero
        reg_write(32'h7FFF_0000);
        chk(reg_rdata == 32'h4FFF_0000, "R10 reserved bits", reg_rdata, 32'h4FFF_0000);

        // R9: isolation while enabled
        ext_mdc = 1'b1; ext_mdio_out = 1'b0; ext_mdio_oe = 1'b1; tb_pull = 1'b0;
        @(negedge clk);
        chk(phy_mdc == 1'b0 && phy_mdio_oe == 1'b0 && ext_mdio_in == 1'b1, "R9 external isolated",
            {phy_mdc, phy_mdio_oe, ext_mdio_in}, 3'b001);
        ext_mdc = 1'b0; ext_mdio_out = 1'b1; ext_mdio_oe = 1'b0; tb_pull = 1'b1;
        @(negedge clk);

        // directed frames
        txn(1'b0, 1'b0, 5'd0,  5'd0,  16'hFFFF);
        txn(1'b1, 1'b0, 5'd0,  5'd0,  16'h0000);
        txn(1'b1, 1'b1, 5'd31, 5'd31, 16'h0000);
        txn(1'b0, 1'b1, 5'd31, 5'd31, 16'h0001);
        txn(1'b1, 1'b0, 5'd4,  5'd31, 16'h0000);
        txn(1'b1, 1'b1, 5'd2,  5'd5,  16'h0000);

        // R8: writes during a frame
        mon_reset();
        rsp_clear();
        ext_mdio_out = 1'b0; ext_mdio_oe = 1'b1;
        reg_write(cmd_word(1'b0, 1'b0, 5'd3, 5'd7, 16'h1234));
        reg_write(cmd_word(1'b1, 1'b1, 5'd9, 5'd2, 16'hFFFF));
        chk(reg_rdata[27:16] == {1'b0, 1'b0, 5'd3, 5'd7}, "R8 fields unchanged while busy",
            reg_rdata[27:16], {2'b00, 5'd3, 5'd7});
        reg_write(32'h0C42_ABCD);
        chk(reg_rdata[31:30] == 2'b10, "R8 enable updated while busy", reg_rdata[31:30], 2'b10);
        chk(phy_mdio_oe == 1'b1 && phy_mdio_out == 1'b0, "R9 disable hands lines to external",
            {phy_mdio_oe, phy_mdio_out}, 2'b10);
        reg_write(32'h4000_0000);
        chk(reg_rdata[31:30] == 2'b11 && reg_rdata[15:0] == 16'h1234, "R8 enable restored, data held",
            reg_rdata, 32'hC067_1234);
        ext_mdio_out = 1'b1; ext_mdio_oe = 1'b0;
        wait_idle();
        check_txn(1'b0, 1'b0, 5'd3, 5'd7, 16'h1234, 1'b0);

        // constrained random frames
        for (int i = 0; i < 20; i++) begin
            bit          r_rd, r_np;
            logic [4:0]  r_phy, r_reg;
            logic [15:0] r_dat;
            r_rd  = 1'($urandom % 2);
            r_np  = 1'($urandom % 2);
            r_phy = 5'($urandom % 32);
            r_reg = 5'($urandom % 32);
            r_dat = 16'($urandom);
            txn(r_rd, r_np, r_phy, r_reg, r_dat);
        end

        summary();
    end

endmodule